// File: doc/BRIEF.md
# Instruction-Cache Alias Invalidator

This block turns a request to invalidate a range of an instruction cache into a stream of line-invalidate commands. The cache is indexed by virtual address and tagged by physical address. When a way is larger than a page, one physical line can sit at more than one set index. A request carries a physical start address, a byte length, an optional virtual address with a flag that says whether it is known, and the ratio of way size to page size. The block aligns the start down to a line boundary and walks every line that the range touches. For each line it issues one command when the virtual address is known. When it is not known, it issues a command for every index the line could occupy.

A build parameter selects one of two command encodings. In the packed encoding, the alias selector goes into the otherwise unused line-offset bits of the physical address. In the split encoding, a tag write carrying the physical line address comes first, and index commands follow it with the alias bits placed just above the page offset. A whole-cache request skips the walk and issues one global command. Commands leave on a valid/ready handshake, and a one-cycle done pulse marks the end of every request. The cache array is outside this block.

Top module: `icinv_top`

## Requirements
- R1: After reset, `cmd_valid` and `done` are 0 and `req_ready` is 1.
- R2: The walk starts at the physical start rounded down to a line (LINE_BYTES = 32). The number of lines is (len + start mod 32 + 31) / 32, rounded down; this is a ceiling division of the widened length by the line size. Successive lines advance by 32.
- R3: A ratio of 0 or 1 gives one alias, 2 gives two and 4 gives four. Any other ratio issues no command and raises `cfg_err` in the same cycle as `done`.
- R4: In the packed encoding with a known virtual address, each line gets exactly one command of kind INDEX (`cmd_kind` = 0). Its data is the line address ORed with vaddr bits [PAGE_SHIFT+4:PAGE_SHIFT] (bits 17:13 with 8 KB pages), placed in data bits 4:0.
- R5: In the packed encoding without a virtual address, each line gets one INDEX command per alias, with data equal to the line address ORed with alias number a, for a = 0, 1, … in ascending order.
- R6: In the split encoding with a known virtual address, each line gets a TAG command (`cmd_kind` = 1) carrying the physical line address, then one INDEX command carrying the line-aligned virtual address. Both addresses advance one line per step.
- R7: In the split encoding without a virtual address, each line gets a TAG command carrying the physical line address. It is followed by one INDEX command per alias, in ascending order, with the line address whose alias bits [PAGE_SHIFT+log2(aliases)-1:PAGE_SHIFT] are replaced by the alias number.
- R8: A whole-cache request issues exactly one command of kind GLOBAL (`cmd_kind` = 2) with data 0, whatever the other request fields hold.
- R9: A command that is not accepted holds its kind and data until `cmd_ready` is seen; one command is accepted per cycle with `cmd_valid` and `cmd_ready` both high.
- R10: `done` is high for exactly one cycle, the cycle after the last command is accepted. A request that covers zero lines gives `done` in the cycle after it is accepted, with no command.
- R11: `req_ready` is high only when no request is in progress, and never while `cmd_valid` or `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_all | input | 1 | Invalidate the whole cache |
| req_paddr | input | ADDR_W | Physical start address |
| req_len | input | LEN_W | Range length in bytes |
| req_vaddr | input | ADDR_W | Virtual start address |
| req_vknown | input | 1 | Virtual address is known |
| req_ratio | input | RATIO_W | Way size divided by page size |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Consumer takes the command |
| cmd_kind | output | 2 | 0 INDEX, 1 TAG, 2 GLOBAL |
| cmd_data | output | ADDR_W | Command address |
| done | output | 1 | One-cycle end-of-request pulse |
| cfg_err | output | 1 | Unsupported ratio, with done |

## Verification
The hardest case to reach is a four-alias walk in which the consumer stalls in the middle of a line's alias run. When it does, the alias counter and the line counter must both hold while the command stays unchanged. The stimulus reaches it by drawing `cmd_ready` at random every cycle over many multi-line requests with ratio 4 and an unknown virtual address. It does this on two instances, one for each encoding. Directed cases cover a start one byte before a line end, zero length, an unsupported ratio and a whole-cache request.

// File: rtl/icinv_pkg.sv
package icinv_pkg;
   typedef enum logic [1:0] {
      CMD_INDEX  = 2'd0,
      CMD_TAG    = 2'd1,
      CMD_GLOBAL = 2'd2
   } cmd_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_GLOBAL,
      ST_TAG,
      ST_INDEX,
      ST_DONE
   } walk_state_e;
endpackage

// File: rtl/icinv_alias_decode.sv
module icinv_alias_decode #(
   parameter int RATIO_W = 4
) (
   input  logic [RATIO_W-1:0] ratio,
   output logic [1:0]         alias_log2,
   output logic               ratio_err
);
   always_comb begin
      alias_log2 = 2'd0;
      ratio_err  = 1'b0;
      case (ratio)
         RATIO_W'(0), RATIO_W'(1): alias_log2 = 2'd0;
         RATIO_W'(2):              alias_log2 = 2'd1;
         RATIO_W'(4):              alias_log2 = 2'd2;
         default:                  ratio_err  = 1'b1;
      endcase
   end
endmodule

// File: rtl/icinv_range_plan.sv
module icinv_range_plan #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int LINE_SHIFT = 5
) (
   input  logic [ADDR_W-1:0] paddr,
   input  logic [ADDR_W-1:0] vaddr,
   input  logic [LEN_W-1:0]  len,
   output logic [ADDR_W-1:0] pline,
   output logic [ADDR_W-1:0] vline,
   output logic [LEN_W:0]    nlines
);
   localparam int CNT_W = LEN_W + 1;
   localparam int LINE_BYTES = 1 << LINE_SHIFT;

   logic [CNT_W-1:0] widened;

   always_comb begin
      widened = {1'b0, len} + CNT_W'(paddr[LINE_SHIFT-1:0]) + CNT_W'(LINE_BYTES - 1);
      nlines  = widened >> LINE_SHIFT;
      pline   = {paddr[ADDR_W-1:LINE_SHIFT], {LINE_SHIFT{1'b0}}};
      vline   = {vaddr[ADDR_W-1:LINE_SHIFT], {LINE_SHIFT{1'b0}}};
   end
endmodule

// File: rtl/icinv_cmd_format.sv
module icinv_cmd_format
   import icinv_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int PAGE_SHIFT = 13,
   parameter bit PACKED     = 1'b1
) (
   input  logic [ADDR_W-1:0] line_p,
   input  logic [ADDR_W-1:0] line_v,
   input  logic [4:0]        vbits,
   input  logic              vknown,
   input  logic [1:0]        alias_idx,
   input  logic [1:0]        alias_log2,
   input  logic              tag_phase,
   output cmd_kind_e         kind,
   output logic [ADDR_W-1:0] data
);
   generate
      if (PACKED) begin : g_packed
         logic unused_split_inputs;
         assign unused_split_inputs = ^{line_v, alias_log2, tag_phase};
         always_comb begin
            kind = CMD_INDEX;
            if (vknown) data = line_p | ADDR_W'(vbits);
            else        data = line_p | ADDR_W'(alias_idx);
         end
      end else begin : g_split
         logic unused_packed_inputs;
         logic [ADDR_W-1:0] amask;
         assign unused_packed_inputs = ^vbits;
         always_comb begin
            amask = ((ADDR_W'(1) << alias_log2) - ADDR_W'(1)) << PAGE_SHIFT;
            if (tag_phase) begin
               kind = CMD_TAG;
               data = line_p;
            end else begin
               kind = CMD_INDEX;
               if (vknown) data = line_v;
               else        data = (line_p & ~amask) | (ADDR_W'(alias_idx) << PAGE_SHIFT);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/icinv_top.sv
module icinv_top
   import icinv_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int RATIO_W    = 4,
   parameter int LINE_BYTES = 32,
   parameter int PAGE_KB    = 8,
   parameter bit PACKED     = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic               req_all,
   input  logic [ADDR_W-1:0]  req_paddr,
   input  logic [LEN_W-1:0]   req_len,
   input  logic [ADDR_W-1:0]  req_vaddr,
   input  logic               req_vknown,
   input  logic [RATIO_W-1:0] req_ratio,
   output logic               cmd_valid,
   input  logic               cmd_ready,
   output logic [1:0]         cmd_kind,
   output logic [ADDR_W-1:0]  cmd_data,
   output logic               done,
   output logic               cfg_err
);
   localparam int LINE_SHIFT = $clog2(LINE_BYTES);
   localparam int PAGE_SHIFT = $clog2(PAGE_KB * 1024);
   localparam walk_state_e FIRST_LINE_ST = PACKED ? ST_INDEX : ST_TAG;

   generate
      if (PAGE_KB != 4 && PAGE_KB != 8 && PAGE_KB != 16) begin : g_bad_page
         $error("PAGE_KB must be 4, 8 or 16");
      end
      if ((1 << LINE_SHIFT) != LINE_BYTES || LINE_BYTES < 32) begin : g_bad_line
         $error("LINE_BYTES must be a power of two of at least 32");
      end
      if (ADDR_W < PAGE_SHIFT + 5) begin : g_bad_addr
         $error("ADDR_W too small for the alias bits");
      end
      if (RATIO_W < 3) begin : g_bad_ratio
         $error("RATIO_W must hold the value 4");
      end
   endgenerate

   walk_state_e       state;
   logic [ADDR_W-1:0] line_p, line_v;
   logic [LEN_W:0]    lines_left;
   logic [1:0]        alias_idx, alias_log2_q;
   logic              vknown_q, err_q;
   logic [4:0]        vbits_q;

   logic [1:0]        dec_log2;
   logic              dec_err;
   logic [ADDR_W-1:0] plan_pline, plan_vline;
   logic [LEN_W:0]    plan_nlines;
   cmd_kind_e         fmt_kind;
   logic [ADDR_W-1:0] fmt_data;

   icinv_alias_decode #(.RATIO_W(RATIO_W)) u_decode (
      .ratio      (req_ratio),
      .alias_log2 (dec_log2),
      .ratio_err  (dec_err)
   );

   icinv_range_plan #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_SHIFT(LINE_SHIFT)) u_plan (
      .paddr  (req_paddr),
      .vaddr  (req_vaddr),
      .len    (req_len),
      .pline  (plan_pline),
      .vline  (plan_vline),
      .nlines (plan_nlines)
   );

   icinv_cmd_format #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .PACKED(PACKED)) u_fmt (
      .line_p     (line_p),
      .line_v     (line_v),
      .vbits      (vbits_q),
      .vknown     (vknown_q),
      .alias_idx  (alias_idx),
      .alias_log2 (alias_log2_q),
      .tag_phase  (state == ST_TAG),
      .kind       (fmt_kind),
      .data       (fmt_data)
   );

   logic       accept, fire, last_alias;
   logic [1:0] alias_max;

   always_comb begin
      accept     = req_valid && req_ready;
      fire       = cmd_valid && cmd_ready;
      case (alias_log2_q)
         2'd1:    alias_max = 2'd1;
         2'd2:    alias_max = 2'd3;
         default: alias_max = 2'd0;
      endcase
      last_alias = vknown_q || (alias_idx == alias_max);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         line_p       <= '0;
         line_v       <= '0;
         lines_left   <= '0;
         alias_idx    <= '0;
         alias_log2_q <= '0;
         vknown_q     <= 1'b0;
         vbits_q      <= '0;
         err_q        <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (accept) begin
               line_p       <= plan_pline;
               line_v       <= plan_vline;
               lines_left   <= plan_nlines;
               alias_idx    <= '0;
               alias_log2_q <= dec_log2;
               vknown_q     <= req_vknown;
               vbits_q      <= req_vaddr[PAGE_SHIFT+4:PAGE_SHIFT];
               if (req_all)                state <= ST_GLOBAL;
               else if (dec_err) begin
                  err_q <= 1'b1;
                  state <= ST_DONE;
               end
               else if (plan_nlines == '0) state <= ST_DONE;
               else                        state <= FIRST_LINE_ST;
            end
            ST_GLOBAL: if (fire) state <= ST_DONE;
            ST_TAG: if (fire) begin
               alias_idx <= '0;
               state     <= ST_INDEX;
            end
            ST_INDEX: if (fire) begin
               if (!last_alias) begin
                  alias_idx <= alias_idx + 2'd1;
               end else begin
                  alias_idx  <= '0;
                  line_p     <= line_p + ADDR_W'(LINE_BYTES);
                  line_v     <= line_v + ADDR_W'(LINE_BYTES);
                  lines_left <= lines_left - 1'b1;
                  state      <= (lines_left == 1) ? ST_DONE : FIRST_LINE_ST;
               end
            end
            ST_DONE: begin
               err_q <= 1'b0;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      req_ready = (state == ST_IDLE);
      cmd_valid = (state == ST_GLOBAL) || (state == ST_TAG) || (state == ST_INDEX);
      done      = (state == ST_DONE);
      cfg_err   = (state == ST_DONE) && err_q;
      if (state == ST_GLOBAL) begin
         cmd_kind = CMD_GLOBAL;
         cmd_data = '0;
      end else begin
         cmd_kind = fmt_kind;
         cmd_data = fmt_data;
      end
   end

   // R9: a stalled command stays unchanged
   assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data) && $stable(cmd_kind));

   // R11: intake closed while busy
   assert_idle_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !cmd_valid && !done);

   // R10: done lasts one cycle
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3: error only with done
   assert_err_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> done);

   // R8: accepted global command ends the request
   assert_global_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready && (cmd_kind == 2'd2) |=> done);

   // R10: a request that is accepted never finishes in the same edge
   assert_accept_not_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);
endmodule

// File: tb/icinv_top_tb.sv
module icinv_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vld_p = 1'b0, vld_s = 1'b0;
   logic        rdy_p = 1'b0, rdy_s = 1'b0;
   logic        r_all = 1'b0, r_vk = 1'b0;
   logic [31:0] r_pa = '0, r_va = '0;
   logic [15:0] r_len = '0;
   logic [3:0]  r_ratio = '0;

   logic        rq_p, cv_p, dn_p, er_p, rq_s, cv_s, dn_s, er_s;
   logic [1:0]  ck_p, ck_s;
   logic [31:0] cd_p, cd_s;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   icinv_top #(.PACKED(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(vld_p), .req_ready(rq_p),
      .req_all(r_all), .req_paddr(r_pa), .req_len(r_len), .req_vaddr(r_va),
      .req_vknown(r_vk), .req_ratio(r_ratio), .cmd_valid(cv_p), .cmd_ready(rdy_p),
      .cmd_kind(ck_p), .cmd_data(cd_p), .done(dn_p), .cfg_err(er_p));

   icinv_top #(.PACKED(1'b0)) u_dut_split (
      .clk(clk), .rst_n(rst_n), .req_valid(vld_s), .req_ready(rq_s),
      .req_all(r_all), .req_paddr(r_pa), .req_len(r_len), .req_vaddr(r_va),
      .req_vknown(r_vk), .req_ratio(r_ratio), .cmd_valid(cv_s), .cmd_ready(rdy_s),
      .cmd_kind(ck_s), .cmd_data(cd_s), .done(dn_s), .cfg_err(er_s));

   logic [1:0]  exp_k [0:1023];
   logic [31:0] exp_d [0:1023];
   int          exp_n;
   bit          exp_err;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   function automatic void push(input logic [1:0] k, input logic [31:0] d);
      exp_k[exp_n] = k;
      exp_d[exp_n] = d;
      exp_n++;
   endfunction

   function automatic void build(input bit split, input bit all, input bit vk,
                                 input logic [31:0] pa, input logic [31:0] va,
                                 input logic [15:0] len, input logic [3:0] ratio);
      int n, lines;
      logic [31:0] base, vbase, la, lv;
      exp_n = 0;
      exp_err = 1'b0;
      if (all) begin
         push(2'd2, 32'h0);
         return;
      end
      case (ratio)
         4'd0, 4'd1: n = 1;
         4'd2:       n = 2;
         4'd4:       n = 4;
         default:    n = 0;
      endcase
      if (n == 0) begin
         exp_err = 1'b1;
         return;
      end
      base  = pa & ~32'h1F;
      vbase = va & ~32'h1F;
      lines = (int'(len) + int'(pa & 32'h1F) + 31) / 32;
      for (int i = 0; i < lines; i++) begin
         la = base + 32'(i * 32);
         lv = vbase + 32'(i * 32);
         if (!split) begin
            if (vk) push(2'd0, la | ((va >> 13) & 32'h1F));
            else for (int a = 0; a < n; a++) push(2'd0, la | 32'(a));
         end else begin
            push(2'd1, la);
            if (vk) push(2'd0, lv);
            else for (int a = 0; a < n; a++)
               push(2'd0, (la & ~(32'(n - 1) << 13)) | (32'(a) << 13));
         end
      end
   endfunction

   task automatic run_req(input bit split, input bit all, input bit vk,
                          input logic [31:0] pa, input logic [31:0] va,
                          input logic [15:0] len, input logic [3:0] ratio,
                          input bit stalls);
      string tag;
      int got, guard;
      bit seen_done, prev_stall, rdy;
      logic [31:0] prev_d;
      logic [1:0] prev_k;
      logic v, dn, er, rq;
      logic [1:0] k;
      logic [31:0] d;
      build(split, all, vk, pa, va, len, ratio);
      if (all) tag = "R8";
      else if (exp_err) tag = "R3";
      else if (split) tag = vk ? "R6" : "R7";
      else tag = vk ? "R4" : "R5";
      @(negedge clk);
      r_all = all; r_vk = vk; r_pa = pa; r_va = va; r_len = len; r_ratio = ratio;
      rq = split ? rq_s : rq_p;
      check(rq === 1'b1, "R11 ready when idle", 32'(rq), 32'h1);
      if (split) vld_s = 1'b1; else vld_p = 1'b1;
      @(negedge clk);
      vld_s = 1'b0; vld_p = 1'b0;
      got = 0; seen_done = 0; guard = 0; prev_stall = 0;
      prev_d = '0; prev_k = '0;
      while (!seen_done && guard < 4000) begin
         v  = split ? cv_s : cv_p;
         k  = split ? ck_s : ck_p;
         d  = split ? cd_s : cd_p;
         dn = split ? dn_s : dn_p;
         er = split ? er_s : er_p;
         rq = split ? rq_s : rq_p;
         if (rq !== 1'b0) check(1'b0, "R11 ready while busy", 32'(rq), 32'h0);
         if (prev_stall) begin
            check(v === 1'b1 && d === prev_d && k === prev_k, "R9 held command", d, prev_d);
         end
         if (dn === 1'b1) begin
            seen_done = 1;
            check(got == exp_n, {tag, " R2 R10 command count at done"}, 32'(got), 32'(exp_n));
            check(er === exp_err, "R3 cfg_err at done", 32'(er), 32'(exp_err));
         end
         rdy = stalls ? ($urandom % 3 != 0) : 1'b1;
         if (split) rdy_s = rdy; else rdy_p = rdy;
         prev_stall = 0;
         if (!seen_done && v === 1'b1) begin
            if (rdy) begin
               if (got < exp_n) begin
                  check(k === exp_k[got] && d === exp_d[got], {tag, " R2 command"}, {d[29:0], k}, {exp_d[got][29:0], exp_k[got]});
               end else begin
                  check(1'b0, {tag, " R10 extra command"}, d, 32'h0);
               end
               got++;
            end else begin
               prev_stall = 1; prev_d = d; prev_k = k;
            end
         end
         @(negedge clk);
         guard++;
      end
      rdy_s = 1'b0; rdy_p = 1'b0;
      if (!seen_done) check(1'b0, "R10 done never seen", 32'(got), 32'(exp_n));
      dn = split ? dn_s : dn_p;
      check(dn === 1'b0, "R10 done one cycle", 32'(dn), 32'h0);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1CE5));
      repeat (3) @(negedge clk);
      check(cv_p === 1'b0 && dn_p === 1'b0 && rq_p === 1'b1, "R1 reset packed", {cv_p, dn_p, rq_p}, 32'h1);
      check(cv_s === 1'b0 && dn_s === 1'b0 && rq_s === 1'b1, "R1 reset split", {cv_s, dn_s, rq_s}, 32'h1);
      rst_n = 1'b1;
      @(negedge clk);

      for (int m = 0; m < 2; m++) begin
         bit sp = (m == 1);
         // R2: slack pushes a two-byte range across a line edge
         run_req(sp, 0, 0, 32'h0000_201F, 32'h0, 16'd2, 4'd4, 0);
         // R10: zero length, aligned start, no commands
         run_req(sp, 0, 0, 32'h0000_4000, 32'h0, 16'd0, 4'd2, 0);
         // R3: unsupported ratio
         run_req(sp, 0, 1, 32'h0000_1234, 32'h0003_E000, 16'd64, 4'd3, 0);
         // R3: ratio 0 acts as one alias
         run_req(sp, 0, 0, 32'h0001_0040, 32'h0, 16'd96, 4'd0, 1);
         // R8: whole cache, other fields ignored
         run_req(sp, 1, 1, 32'hFFFF_FFFF, 32'h1234_5678, 16'd500, 4'd7, 1);
         // R4 R6: known virtual address with high alias bits set
         run_req(sp, 0, 1, 32'h8000_0010, 32'h0003_E008, 16'd80, 4'd4, 1);
         // R5 R7: four aliases with stalls
         run_req(sp, 0, 0, 32'h8000_7FE4, 32'h0, 16'd100, 4'd4, 1);
      end

      for (int i = 0; i < 300; i++) begin
         bit sp = ($urandom % 2) == 1;
         bit al = ($urandom % 10) == 0;
         bit vk = ($urandom % 2) == 1;
         int rsel = $urandom % 12;
         logic [3:0] ra;
         case (rsel)
            0, 1, 2: ra = 4'd4;
            3, 4, 5: ra = 4'd2;
            6, 7:    ra = 4'd1;
            8:       ra = 4'd0;
            9:       ra = 4'($urandom % 16);
            default: ra = 4'd4;
         endcase
         run_req(sp, al, vk, $urandom, $urandom, 16'($urandom % 200), ra, 1);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule